// File: doc/BRIEF.md
# Single-Port RAM with Registered Inputs

This block is a small single-port memory of 32 words, each 4 bits wide. One 5-bit address selects the word for both reading and writing. On each rising clock edge the address, the write data and the write enable are captured into input registers. Those captured values control everything that follows.

A write lands in the array on the edge after the write enable was captured, at the captured address. The read data is not registered. It is decoded straight from the array at the captured address, so a new address shows up at the output one edge after it is presented. A word just written is visible as soon as the write edge has passed.

A synchronous, active-high reset clears only the input registers: captured address zero and captured write enable low. The array contents are never cleared and stay undefined until written.

Top module: `spram_reg_in`

## Requirements
- R1: The address, write data and write enable are sampled only on the rising clock edge. A change to any of them between edges leaves the read data unchanged until the next edge.
- R2: When the captured write enable is 1 at a rising edge, the captured write data is stored into the word chosen by the captured address. Every other word keeps its value.
- R3: The read data always equals the stored word at the captured address. A new address presented before an edge is reflected in the read data immediately after that edge, with no further register stage.
- R4: Once the edge that performs a write has passed, the read data at that address shows the new word in the same cycle.
- R5: When the captured write enable is 0, the array is not modified, whatever the write data and address inputs carry.
- R6: While reset is high at a rising edge, the captured write enable becomes 0 and the captured address becomes 0. No write occurs during reset, and the stored words survive it.
- R7: All 32 addresses, 0 through 31, hold independent words. Writing one location does not change the value read back from any other.
- R8: Writes to the same address on consecutive cycles with the write enable held high leave the word from the last of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers and the array |
| rst | input | 1 | Synchronous active-high reset of the input registers |
| addr | input | 5 | Shared read/write word address |
| wdata | input | 4 | Word to be written |
| wen | input | 1 | Write enable, 1 = write |
| rdata | output | 4 | Unregistered read word at the captured address |

## Verification
The bench writes every address with a pattern computed from its address and reads each one back. It then rewrites all 32 addresses on consecutive cycles with the enable held high. A decode fault or an aliased address bit would return another location's word. A design that wrote at the capture edge, or added an output register, would show the new word one cycle early or late.

Back-to-back writes to one address catch a design that keeps an earlier value. Changing the inputs between edges and holding write data with the enable low catch a design that reads or writes unclocked inputs. A reset applied with the enable high catches a reset that lets a write through or clears the stored words.

// File: rtl/spram_pkg.sv
package spram_pkg;

    localparam int unsigned DEF_WORDS = 32;
    localparam int unsigned DEF_BITS  = 4;

    // number of address bits needed to reach every word
    function automatic int unsigned index_bits(input int unsigned words);
        return (words <= 1) ? 1 : $clog2(words);
    endfunction

endpackage

// File: rtl/spram_in_reg.sv
module spram_in_reg #(
    parameter int unsigned AW = 5,
    parameter int unsigned DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    input  logic          we_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          we_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o <= '0;
            data_o <= '0;
            we_o   <= 1'b0;
        end else begin
            addr_o <= addr_i;
            data_o <= data_i;
            we_o   <= we_i;
        end
    end

endmodule

// File: rtl/spram_array.sv
module spram_array #(
    parameter int unsigned WORDS = 32,
    parameter int unsigned AW    = 5,
    parameter int unsigned DW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] wword,
    output logic [DW-1:0] rword
);

    logic [DW-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[idx] <= wword;
        end
    end

    assign rword = cells[idx];

endmodule

// File: rtl/spram_reg_in.sv
module spram_reg_in
    import spram_pkg::*;
#(
    parameter int unsigned WORDS = DEF_WORDS,
    parameter int unsigned DW    = DEF_BITS,
    localparam int unsigned AW   = index_bits(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wen,
    output logic [DW-1:0] rdata
);

    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          wen_q;

    spram_in_reg #(
        .AW (AW),
        .DW (DW)
    ) u_in (
        .clk    (clk),
        .rst    (rst),
        .addr_i (addr),
        .data_i (wdata),
        .we_i   (wen),
        .addr_o (addr_q),
        .data_o (wdata_q),
        .we_o   (wen_q)
    );

    spram_array #(
        .WORDS (WORDS),
        .AW    (AW),
        .DW    (DW)
    ) u_mem (
        .clk   (clk),
        .we    (wen_q),
        .idx   (addr_q),
        .wword (wdata_q),
        .rword (rdata)
    );

endmodule

// File: rtl/spram_reg_in_chk.sv
module spram_reg_in_chk #(
    parameter int unsigned AW = 5,
    parameter int unsigned DW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] rdata,
    input logic [AW-1:0] addr_q,
    input logic [DW-1:0] wdata_q,
    input logic          wen_q
);

    // R6
    reset_capture_chk: assert property (@(posedge clk)
        rst |=> (wen_q == 1'b0 && addr_q == '0));

    // R1
    addr_sampled_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> addr_q == $past(addr));

    // R4
    write_visible_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(wen_q) && addr_q == $past(addr_q)) |-> rdata == $past(wdata_q));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(wen_q) && !$past(rst) && addr_q == $past(addr_q)) |-> $stable(rdata));

endmodule

bind spram_reg_in spram_reg_in_chk #(
    .AW (AW),
    .DW (DW)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .rdata   (rdata),
    .addr_q  (addr_q),
    .wdata_q (wdata_q),
    .wen_q   (wen_q)
);

// File: tb/spram_reg_in_tb.sv
`timescale 1ns/1ps
module spram_reg_in_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] addr = '0;
    logic [3:0] wdata = '0;
    logic       wen = 1'b0;
    logic [3:0] rdata;

    logic [3:0] model [32];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    spram_reg_in u_dut (
        .clk   (clk),
        .rst   (rst),
        .addr  (addr),
        .wdata (wdata),
        .wen   (wen),
        .rdata (rdata)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // write one word, then one idle cycle; output read after the write edge
    task automatic write_word(input logic [4:0] a, input logic [3:0] d, input string req);
        addr = a; wdata = d; wen = 1'b1;
        tick();
        wen = 1'b0;
        tick();
        model[a] = d;
        check(req, rdata, d);
    endtask

    task automatic read_word(input logic [4:0] a, input string req);
        addr = a; wen = 1'b0;
        tick();
        check(req, rdata, model[a]);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R2 R4: write every address with an arithmetic pattern
        for (int a = 0; a < 32; a++) begin
            write_word(5'(a), 4'((a * 7 + 3) & 15), "R4");
        end
        // R7 R3: read all back
        for (int a = 0; a < 32; a++) begin
            read_word(5'(a), "R7");
        end

        // R2 R7: continuous writes, one address per cycle, enable held high
        for (int a = 0; a < 32; a++) begin
            addr = 5'(a); wdata = 4'(~((a * 5 + 1) & 15)); wen = 1'b1;
            model[a] = 4'(~((a * 5 + 1) & 15));
            tick();
        end
        wen = 1'b0;
        tick();
        for (int a = 31; a >= 0; a--) begin
            read_word(5'(a), "R2");
        end

        // R8: back-to-back writes to one address
        addr = 5'd9; wen = 1'b1;
        wdata = 4'h1; tick();
        wdata = 4'h6; tick();
        wdata = 4'hC; tick();
        wen = 1'b0; tick();
        model[9] = 4'hC;
        check("R8", rdata, 4'hC);
        read_word(5'd8, "R8");
        read_word(5'd9, "R8");

        // R3: address change visible right after one edge
        read_word(5'd2, "R3");
        addr = 5'd30;
        tick();
        check("R3", rdata, model[30]);

        // R1: change inputs between edges, output must hold until next edge
        addr = 5'd4;
        tick();
        @(posedge clk); #1;
        addr = 5'd17; wdata = 4'hF; wen = 1'b1;
        #1;
        check("R1", rdata, model[4]);
        wen = 1'b0; addr = 5'd4;
        tick();
        check("R1", rdata, model[4]);

        // R5: enable low with differing data leaves array unchanged
        addr = 5'd12; wdata = ~model[12]; wen = 1'b0;
        tick(); tick();
        check("R5", rdata, model[12]);
        read_word(5'd12, "R5");

        // R6: reset with write enable high writes nothing and keeps contents
        write_word(5'd0, 4'h5, "R6");
        addr = 5'd0; wdata = 4'hA; wen = 1'b1; rst = 1'b1;
        tick(); tick(); tick();
        check("R6", rdata, 4'h5);
        addr = 5'd21; wen = 1'b0;
        tick();
        check("R6", rdata, 4'h5);
        rst = 1'b0;
        tick();
        check("R6", rdata, model[21]);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule